// File: doc/BRIEF.md
# Window Watchdog Reset Sequencer

This block supervises a processor through an active-low reset line. After a power-on clear, and after every supply dip, it holds the reset low for a reset delay. While the output voltage is good it counts that delay in ticks of a slow timebase and then releases the line. From that point the processor has to service the watchdog inside windows. First comes a window in which service pulses are dropped. Next is a long first open window. After that, closed and open windows alternate. A service pulse that arrives while a window is closed causes a reset, and so does an open window that runs out with no pulse. In both cases the sequence starts again from the reset delay.

Service pulses come from a separate decoder as one-cycle valid-trigger strobes. All durations are whole ticks of the `tick` input, which is one clock wide and nominally every 0.5 ms. Two static select pins choose fast or slow timing for the watchdog and for the reset delay, or switch the watchdog off. When the watchdog is off, or the load-current-high flag is low, the block sits in a disabled state with reset released. When the watchdog is enabled again, the sequence resumes at the window that drops pulses.

States: HOLD (reset asserted, delay running), IGNORE, LONG_OPEN, CLOSED, OPEN, DISABLED. Transitions:
- HOLD→IGNORE when the delay expires.
- IGNORE→LONG_OPEN when it expires.
- LONG_OPEN→CLOSED on a trigger, and LONG_OPEN→HOLD on expiry.
- CLOSED→OPEN on expiry, and CLOSED→HOLD on a trigger.
- OPEN→CLOSED on a trigger, and OPEN→HOLD on expiry.
- Any watchdog state→DISABLED when the watchdog is not enabled.
- DISABLED→IGNORE when it is enabled again.
- Any state→HOLD while the voltage-good flag is low.

Top module: `wwdg_rst_seq`

## Requirements
- R1: A synchronous high `rst` puts the block in HOLD with `rst_n_out` low, and the delay count starts from zero.
- R2: The select pins `{sel_a, sel_b}` decode as follows. 00 gives fast watchdog and fast delay. 01 gives slow watchdog and slow delay. 10 gives fast watchdog and slow delay. 11 turns the watchdog off and uses the slow delay. Slow durations are SLOW_FACTOR times the fast ones.
- R3: In HOLD with `vgood` high, `rst_n_out` rises on the tick that completes RD_FAST_TICKS ticks in fast mode, or RD_FAST_TICKS×SLOW_FACTOR ticks in slow mode. It rises only on a tick.
- R4: The IGNORE window lasts one window length, which is WIN_FAST_TICKS in fast mode. Triggers inside it have no effect.
- R5: LONG_OPEN lasts LONG_FACTOR window lengths. A trigger inside it moves the block to CLOSED. Expiry with no trigger drives `rst_n_out` low.
- R6: A trigger during CLOSED drives `rst_n_out` low in the next cycle. When CLOSED expires, OPEN begins and the reset stays released.
- R7: A trigger during OPEN moves the block to CLOSED. If OPEN expires after one window length with no trigger, `rst_n_out` goes low.
- R8: A trigger in the same cycle as a window's expiry tick belongs to the window that is ending. In OPEN or LONG_OPEN it is accepted. In CLOSED it causes a reset.
- R9: While `load_hi` is low, or the mode is 11, no watchdog reset occurs and `rst_n_out` stays high. When the watchdog is enabled again, the sequence restarts at IGNORE.
- R10: `vgood` low drives `rst_n_out` low in the next cycle and keeps it low. Once `vgood` returns, the full reset delay elapses before release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on clear |
| tick | input | 1 | One-cycle timebase strobe (0.5 ms nominal) |
| vgood | input | 1 | Output voltage good flag |
| load_hi | input | 1 | Load current above watchdog activation level |
| sel_a | input | 1 | Mode select, high-order bit |
| sel_b | input | 1 | Mode select, low-order bit |
| trig | input | 1 | One-cycle valid service trigger |
| rst_n_out | output | 1 | Active-low reset to the processor |

## Verification
The bench runs every mode code through a release-and-starve sequence. The reset delay and the ignore-plus-long-window span it measures, counted tick by tick, show whether the select decode and the slow factor are wired correctly. Service patterns are then placed in each window: a trigger inside the ignore window, early triggers, a late trigger, triggers on the exact expiry tick of open and closed windows, and no trigger at all. These patterns separate accepted service from early-service resets and from missing-service resets. Supply dips and load-flag drops, applied in the middle of a window, show whether the delay restarts in full and whether the sequence resumes at the ignore window.

// File: rtl/wwdg_pkg.sv
package wwdg_pkg;

    typedef enum logic [2:0] {
        ST_HOLD,
        ST_IGNORE,
        ST_LONG_OPEN,
        ST_CLOSED,
        ST_OPEN,
        ST_DISABLED
    } wd_state_t;

    typedef struct packed {
        logic wd_off;
        logic wd_slow;
        logic rst_slow;
    } mode_cfg_t;

endpackage

// File: rtl/wwdg_mode_dec.sv
module wwdg_mode_dec
    import wwdg_pkg::*;
(
    input  logic      sel_a,
    input  logic      sel_b,
    output mode_cfg_t cfg
);
    always_comb begin
        unique case ({sel_a, sel_b})
            2'b00:   cfg = '{wd_off: 1'b0, wd_slow: 1'b0, rst_slow: 1'b0};
            2'b01:   cfg = '{wd_off: 1'b0, wd_slow: 1'b1, rst_slow: 1'b1};
            2'b10:   cfg = '{wd_off: 1'b0, wd_slow: 1'b0, rst_slow: 1'b1};
            default: cfg = '{wd_off: 1'b1, wd_slow: 1'b0, rst_slow: 1'b1};
        endcase
    end
endmodule

// File: rtl/wwdg_tick_timer.sv
module wwdg_tick_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= cnt_q + 1'b1;
    end

    // Expiry fires on the tick that completes `limit` ticks.
    assign expire = tick && (cnt_q == limit - 1'b1);
endmodule

// File: rtl/wwdg_rst_seq.sv
module wwdg_rst_seq
    import wwdg_pkg::*;
#(
    parameter int RD_FAST_TICKS  = 32,
    parameter int WIN_FAST_TICKS = 64,
    parameter int SLOW_FACTOR    = 2,
    parameter int LONG_FACTOR    = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic vgood,
    input  logic load_hi,
    input  logic sel_a,
    input  logic sel_b,
    input  logic trig,
    output logic rst_n_out
);
    localparam int RD_MAX   = RD_FAST_TICKS * SLOW_FACTOR;
    localparam int LONG_MAX = WIN_FAST_TICKS * SLOW_FACTOR * LONG_FACTOR;
    localparam int CNT_MAX  = (RD_MAX > LONG_MAX) ? RD_MAX : LONG_MAX;
    localparam int CNT_W    = $clog2(CNT_MAX + 1);

    localparam logic [CNT_W-1:0] RD_F   = CNT_W'(RD_FAST_TICKS);
    localparam logic [CNT_W-1:0] RD_S   = CNT_W'(RD_MAX);
    localparam logic [CNT_W-1:0] WIN_F  = CNT_W'(WIN_FAST_TICKS);
    localparam logic [CNT_W-1:0] WIN_S  = CNT_W'(WIN_FAST_TICKS * SLOW_FACTOR);
    localparam logic [CNT_W-1:0] LONG_F = CNT_W'(WIN_FAST_TICKS * LONG_FACTOR);
    localparam logic [CNT_W-1:0] LONG_S = CNT_W'(LONG_MAX);

    mode_cfg_t        cfg;
    wd_state_t        state_q, state_d;
    logic [CNT_W-1:0] limit;
    logic             expire;
    logic             clr;
    logic             wd_en;

    wwdg_mode_dec i_mode (
        .sel_a (sel_a),
        .sel_b (sel_b),
        .cfg   (cfg)
    );

    wwdg_tick_timer #(.CNT_W(CNT_W)) i_timer (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr),
        .tick   (tick),
        .limit  (limit),
        .expire (expire)
    );

    assign wd_en = load_hi && !cfg.wd_off;

    // Duration of the current state
    always_comb begin
        unique case (state_q)
            ST_HOLD:      limit = cfg.rst_slow ? RD_S : RD_F;
            ST_LONG_OPEN: limit = cfg.wd_slow ? LONG_S : LONG_F;
            default:      limit = cfg.wd_slow ? WIN_S : WIN_F;
        endcase
    end

    // Next-state logic: supply loss first, then enable, then trigger, then expiry
    always_comb begin
        state_d = state_q;
        if (!vgood) begin
            state_d = ST_HOLD;
        end else begin
            unique case (state_q)
                ST_HOLD:
                    if (expire) state_d = ST_IGNORE;
                ST_DISABLED:
                    if (wd_en) state_d = ST_IGNORE;
                ST_IGNORE:
                    if (!wd_en)      state_d = ST_DISABLED;
                    else if (expire) state_d = ST_LONG_OPEN;
                ST_LONG_OPEN, ST_OPEN:
                    if (!wd_en)      state_d = ST_DISABLED;
                    else if (trig)   state_d = ST_CLOSED;
                    else if (expire) state_d = ST_HOLD;
                ST_CLOSED:
                    if (!wd_en)      state_d = ST_DISABLED;
                    else if (trig)   state_d = ST_HOLD;
                    else if (expire) state_d = ST_OPEN;
                default:
                    state_d = ST_HOLD;
            endcase
        end
    end

    assign clr = (state_d != state_q) || (state_q == ST_HOLD && !vgood);

    // State register
    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_HOLD;
        else
            state_q <= state_d;
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            ST_HOLD: rst_n_out = 1'b0;
            default: rst_n_out = 1'b1;
        endcase
    end
endmodule

// File: rtl/wwdg_rst_seq_chk.sv
module wwdg_rst_seq_chk
    import wwdg_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      tick,
    input logic      vgood,
    input logic      load_hi,
    input logic      sel_a,
    input logic      sel_b,
    input logic      trig,
    input logic      rst_n_out,
    input wd_state_t state_q
);
    logic enabled;
    assign enabled = load_hi && !(sel_a && sel_b);

    a_r10_supply_loss: assert property (@(posedge clk) disable iff (rst)
        !vgood |=> !rst_n_out);

    a_r3_release_on_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_n_out) |-> $past(tick));

    a_r9_disabled_no_reset: assert property (@(posedge clk) disable iff (rst)
        (rst_n_out && vgood && !enabled) |=> rst_n_out);

    a_r6_early_trigger: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CLOSED && trig && vgood && enabled) |=> !rst_n_out);

    a_r4_ignore_holds: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IGNORE && vgood) |=> rst_n_out);

    a_r7_open_trigger: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_OPEN && trig && vgood && enabled) |=> (state_q == ST_CLOSED));
endmodule

bind wwdg_rst_seq wwdg_rst_seq_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .vgood     (vgood),
    .load_hi   (load_hi),
    .sel_a     (sel_a),
    .sel_b     (sel_b),
    .trig      (trig),
    .rst_n_out (rst_n_out),
    .state_q   (state_q)
);

// File: tb/test_wwdg_rst_seq.sv
module test_wwdg_rst_seq;
    localparam int RDF  = 3;
    localparam int WINF = 4;
    localparam int SLOW = 2;
    localparam int LONG = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic vgood = 1'b1;
    logic load_hi = 1'b1;
    logic sel_a = 1'b0;
    logic sel_b = 1'b0;
    logic trig = 1'b0;
    logic rst_n_out;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    wwdg_rst_seq #(
        .RD_FAST_TICKS  (RDF),
        .WIN_FAST_TICKS (WINF),
        .SLOW_FACTOR    (SLOW),
        .LONG_FACTOR    (LONG)
    ) i_wwdg_rst_seq (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .vgood     (vgood),
        .load_hi   (load_hi),
        .sel_a     (sel_a),
        .sel_b     (sel_b),
        .trig      (trig),
        .rst_n_out (rst_n_out)
    );

    task automatic cyc(input logic tk, input logic tg);
        tick = tk;
        trig = tg;
        @(posedge clk);
        #1;
        tick = 1'b0;
        trig = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0);
    endtask

    task automatic chk(input string rq, input logic exp);
        checks++;
        if (rst_n_out !== exp) begin
            errors++;
            $display("FAIL %s rst_n_out=%0b expected %0b", rq, rst_n_out, exp);
        end
    endtask

    // n-1 ticks then check exp_before, one tick more then check exp_after
    task automatic run(input string rq, input int n, input logic exp_before, input logic exp_after);
        ticks(n - 1);
        chk(rq, exp_before);
        ticks(1);
        chk(rq, exp_after);
    endtask

    task automatic start(input logic a, input logic b);
        sel_a = a;
        sel_b = b;
        rst = 1'b1;
        cyc(1'b0, 1'b0);
        rst = 1'b0;
        chk("R1", 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // Fast mode 00
        start(1'b0, 1'b0);
        run("R3", RDF, 1'b0, 1'b1);
        cyc(1'b0, 1'b1);                       // R4: trigger inside ignore window
        chk("R4", 1'b1);
        ticks(1);
        run("R4", WINF - 1 + WINF * LONG, 1'b1, 1'b0);   // R5 long window expiry
        // Service in long window, closed, open, early trigger
        run("R3", RDF, 1'b0, 1'b1);
        ticks(WINF);
        ticks(5);
        cyc(1'b0, 1'b1);
        chk("R5", 1'b1);
        run("R6", WINF, 1'b1, 1'b1);
        ticks(2);
        cyc(1'b0, 1'b1);
        chk("R7", 1'b1);
        ticks(1);
        cyc(1'b0, 1'b1);
        chk("R6", 1'b0);
        // Open window expiry
        run("R3", RDF, 1'b0, 1'b1);
        ticks(WINF);
        cyc(1'b0, 1'b1);
        ticks(WINF);
        run("R7", WINF, 1'b1, 1'b0);
        // Trigger on expiry tick
        run("R3", RDF, 1'b0, 1'b1);
        ticks(WINF);
        cyc(1'b0, 1'b1);
        ticks(WINF);
        ticks(WINF - 1);
        cyc(1'b1, 1'b1);
        chk("R8", 1'b1);
        ticks(WINF - 1);
        cyc(1'b1, 1'b1);
        chk("R8", 1'b0);
        // Supply dip during closed window
        run("R3", RDF, 1'b0, 1'b1);
        ticks(WINF);
        cyc(1'b0, 1'b1);
        vgood = 1'b0;
        cyc(1'b0, 1'b0);
        chk("R10", 1'b0);
        ticks(10);
        chk("R10", 1'b0);
        vgood = 1'b1;
        run("R10", RDF, 1'b0, 1'b1);
        // Load flag low while in ignore window
        load_hi = 1'b0;
        cyc(1'b0, 1'b0);
        ticks(40);
        cyc(1'b0, 1'b1);
        chk("R9", 1'b1);
        load_hi = 1'b1;
        cyc(1'b0, 1'b1);
        run("R9", WINF + WINF * LONG, 1'b1, 1'b0);
        // Mode 11: watchdog off, slow delay
        start(1'b1, 1'b1);
        run("R2", RDF * SLOW, 1'b0, 1'b1);
        ticks(60);
        cyc(1'b0, 1'b1);
        chk("R2", 1'b1);
        // Mode 01: slow watchdog, slow delay
        start(1'b0, 1'b1);
        run("R2", RDF * SLOW, 1'b0, 1'b1);
        run("R2", WINF * SLOW * (1 + LONG), 1'b1, 1'b0);
        run("R2", RDF * SLOW, 1'b0, 1'b1);
        ticks(WINF * SLOW);
        cyc(1'b0, 1'b1);
        ticks(WINF * SLOW);
        run("R2", WINF * SLOW, 1'b1, 1'b0);
        // Mode 10: fast watchdog, slow delay
        start(1'b1, 1'b0);
        run("R2", RDF * SLOW, 1'b0, 1'b1);
        run("R2", WINF * (1 + LONG), 1'b1, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule